// File: doc/BRIEF.md
# Quadrature Position Decoder with Speed Timers and Stall Watchdog

This block turns the two phase signals of an incremental encoder into a position count. Every transition of either phase moves the count by one, so a full phase cycle yields four counts, and the order in which the phases change gives the direction. The count runs between zero and a programmable ceiling and wraps around it in both directions. The phase inputs are expected to arrive already synchronised to the block clock.

Two timing aids cover the two speed ranges. A unit timer copies the position into a latch at a fixed programmable period, so the distance travelled per period gives the speed when motion is fast. A 16-bit capture timer measures the number of clock cycles between consecutive counted edges, which gives the speed when motion is slow. A watchdog raises a stall flag when no phase transition arrives within a programmed number of cycles. A separate error flag is raised when both phases change in the same clock, which a valid encoder never does.

Software programs the block through a simple write port and reads it back through a combinational read port. Events are collected as sticky flags that can be cleared by writing ones. A masked OR of the flags drives a single interrupt line.

Top module: `qdec_top`

## Requirements
- R1: Each single-phase transition counts once. The (A,B) sequence 00→10→11→01→00 increments the position and the reverse order decrements it. After a counted step, dir_o is 1 for an increment and 0 for a decrement.
- R2: The ceiling register at address 2 resets to all ones. An increment from the ceiling (or from above it) gives 0, and a decrement from 0 gives the ceiling.
- R3: When A and B both change in the same cycle, the position does not move and flags_o bit 2 is set, whatever the control bits are.
- R4: A write to address 1 loads the position, and pos_o shows the new value after that clock edge. A write in the same cycle as a counted edge takes priority over the count.
- R5: With control bit 1 set and period P at address 3, every P+1 cycles the position is copied into the latch read at address 4 and flags_o bit 0 is set.
- R6: With control bit 3 set, each counted edge stores at address 6 the number of cycles since the previous counted edge. If the 16-bit capture counter reaches 65535 with no edge, it wraps and sets flags_o bit 3.
- R7: With control bit 2 set and timeout T at address 5, flags_o bit 1 is set once T+1 cycles pass after enabling or after the last phase transition with no further transition. Any transition restarts the count.
- R8: Flags are sticky. Writing ones at address 7 clears those bits, and a new event in the same cycle wins over the clear. irq is high when any flag is set whose bit is set in the mask at address 8.
- R9: After reset, pos_o is 0, dir_o is 0, flags_o is 0 and irq is 0.
- R10: Control bit 0 at address 0 enables counting. While it is 0, phase transitions leave the position unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| qa | input | 1 | Phase A, synchronised |
| qb | input | 1 | Phase B, synchronised |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | DATA_W | Read data (combinational) |
| pos_o | output | POS_W | Current position |
| dir_o | output | 1 | Direction of the last counted step |
| flags_o | output | 4 | Sticky event flags |
| irq | output | 1 | Masked interrupt request |

## Verification
A phase change driven before a clock edge appears on pos_o, dir_o and the error flag right after that edge, so the bench samples at the following falling edge. A register write likewise takes effect at the edge where it is strobed. The unit-timer and watchdog flags are due exactly P+1 and T+1 edges after the enabling write or after the restarting transition. The bench counts falling edges from that point, checks that the flag is still clear one edge early and set exactly on time. Capture values are compared with the number of edges the bench waited between two driven transitions. The capture overflow is checked once before and once after the 65535-cycle mark.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
   localparam int unsigned REG_AW = 4;
   typedef logic [REG_AW-1:0] qdec_addr_t;

   // register addresses
   localparam qdec_addr_t A_CTRL = 4'd0;
   localparam qdec_addr_t A_POS  = 4'd1;
   localparam qdec_addr_t A_PMAX = 4'd2;
   localparam qdec_addr_t A_UPRD = 4'd3;
   localparam qdec_addr_t A_PLAT = 4'd4;
   localparam qdec_addr_t A_WDTO = 4'd5;
   localparam qdec_addr_t A_CLAT = 4'd6;
   localparam qdec_addr_t A_FLAG = 4'd7;
   localparam qdec_addr_t A_IMSK = 4'd8;

   // control bits
   localparam int unsigned NCTRL  = 4;
   localparam int unsigned C_CNT  = 0;
   localparam int unsigned C_UNIT = 1;
   localparam int unsigned C_WDOG = 2;
   localparam int unsigned C_CAP  = 3;

   // flag bits
   localparam int unsigned NFLAG   = 4;
   localparam int unsigned F_UNIT  = 0;
   localparam int unsigned F_STALL = 1;
   localparam int unsigned F_PERR  = 2;
   localparam int unsigned F_COVF  = 3;
endpackage

// File: rtl/qdec_decoder.sv
module qdec_decoder (
   input  logic clk,
   input  logic rst_n,
   input  logic qa,
   input  logic qb,
   output logic cnt_evt,
   output logic up_evt,
   output logic err_evt,
   output logic edge_evt
);
   logic pa_q, pb_q;
   logic chg_a, chg_b;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pa_q <= 1'b0;
         pb_q <= 1'b0;
      end else begin
         pa_q <= qa;
         pb_q <= qb;
      end
   end

   assign chg_a    = qa ^ pa_q;
   assign chg_b    = qb ^ pb_q;
   assign edge_evt = chg_a | chg_b;
   assign err_evt  = chg_a & chg_b;
   assign cnt_evt  = chg_a ^ chg_b;
   // forward order: new A differs from old B
   assign up_evt   = qa ^ pb_q;
endmodule

// File: rtl/qdec_position.sv
module qdec_position #(
   parameter int unsigned POS_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             step,
   input  logic             up,
   input  logic             load,
   input  logic [POS_W-1:0] load_val,
   input  logic [POS_W-1:0] ceil_val,
   output logic [POS_W-1:0] pos,
   output logic             dir
);
   logic             do_step;
   logic [POS_W-1:0] pos_inc, pos_dec;

   assign do_step = en && step;
   assign pos_inc = (pos >= ceil_val) ? '0 : pos + POS_W'(1);
   assign pos_dec = (pos == '0) ? ceil_val : pos - POS_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos <= '0;
         dir <= 1'b0;
      end else begin
         if (load)         pos <= load_val;
         else if (do_step) pos <= up ? pos_inc : pos_dec;
         if (do_step)      dir <= up;
      end
   end
endmodule

// File: rtl/qdec_period_tmr.sv
module qdec_period_tmr #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         clr,
   input  logic [W-1:0] limit,
   output logic         hit
);
   logic [W-1:0] cnt;
   logic         at_lim;

   assign at_lim = (cnt >= limit);
   assign hit    = en && !clr && at_lim;

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt <= '0;
      else if (!en || clr)     cnt <= '0;
      else if (at_lim)         cnt <= '0;
      else                     cnt <= cnt + W'(1);
   end
endmodule

// File: rtl/qdec_capture.sv
module qdec_capture #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         evt,
   output logic [W-1:0] latch,
   output logic         ovf
);
   logic [W-1:0] cnt;
   logic         full;

   assign full = (cnt == {W{1'b1}});
   assign ovf  = en && !evt && full;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt   <= '0;
         latch <= '0;
      end else if (!en) begin
         cnt   <= '0;
      end else if (evt) begin
         latch <= cnt;
         cnt   <= W'(1);
      end else if (full) begin
         cnt   <= '0;
      end else begin
         cnt   <= cnt + W'(1);
      end
   end
endmodule

// File: rtl/qdec_top.sv
module qdec_top
   import qdec_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned POS_W     = 32,
   parameter int unsigned UT_W      = 32,
   parameter int unsigned WD_W      = 16,
   parameter int unsigned CAP_W     = 16,
   parameter bit          HAS_WDOG  = 1'b1,
   parameter bit          HAS_CAP   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              qa,
   input  logic              qb,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [REG_AW-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic [POS_W-1:0]  pos_o,
   output logic              dir_o,
   output logic [NFLAG-1:0]  flags_o,
   output logic              irq
);
   // elaboration checks
   if (POS_W < 2 || POS_W > DATA_W) begin : g_bad_pos
      $error("qdec_top: POS_W must lie in 2..DATA_W");
   end
   if (UT_W < 1 || UT_W > DATA_W) begin : g_bad_ut
      $error("qdec_top: UT_W must lie in 1..DATA_W");
   end
   if (WD_W < 1 || WD_W > DATA_W) begin : g_bad_wd
      $error("qdec_top: WD_W must lie in 1..DATA_W");
   end
   if (CAP_W < 2 || CAP_W > DATA_W) begin : g_bad_cap
      $error("qdec_top: CAP_W must lie in 2..DATA_W");
   end
   if (DATA_W < NCTRL || DATA_W < NFLAG) begin : g_bad_data
      $error("qdec_top: DATA_W too narrow for control or flag field");
   end

   logic [NCTRL-1:0] ctrl;
   logic [POS_W-1:0] ceil_q, pos_latch;
   logic [UT_W-1:0]  unit_prd;
   logic [WD_W-1:0]  wd_to;
   logic [NFLAG-1:0] flags, imask, flag_set, flag_clr;
   logic [CAP_W-1:0] cap_latch;
   logic             cnt_evt, up_evt, err_evt, edge_evt;
   logic             unit_hit, stall_hit, cap_ovf;
   logic             pos_wr;

   assign pos_wr = wr_en && (wr_addr == A_POS);

   qdec_decoder u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .qa       (qa),
      .qb       (qb),
      .cnt_evt  (cnt_evt),
      .up_evt   (up_evt),
      .err_evt  (err_evt),
      .edge_evt (edge_evt)
   );

   qdec_position #(.POS_W(POS_W)) u_pos (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (ctrl[C_CNT]),
      .step     (cnt_evt),
      .up       (up_evt),
      .load     (pos_wr),
      .load_val (wr_data[POS_W-1:0]),
      .ceil_val (ceil_q),
      .pos      (pos_o),
      .dir      (dir_o)
   );

   qdec_period_tmr #(.W(UT_W)) u_unit (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (ctrl[C_UNIT]),
      .clr   (1'b0),
      .limit (unit_prd),
      .hit   (unit_hit)
   );

   if (HAS_WDOG) begin : g_wdog
      qdec_period_tmr #(.W(WD_W)) u_wdog (
         .clk   (clk),
         .rst_n (rst_n),
         .en    (ctrl[C_WDOG]),
         .clr   (edge_evt),
         .limit (wd_to),
         .hit   (stall_hit)
      );
   end else begin : g_no_wdog
      assign stall_hit = 1'b0;
   end

   if (HAS_CAP) begin : g_cap
      qdec_capture #(.W(CAP_W)) u_cap (
         .clk   (clk),
         .rst_n (rst_n),
         .en    (ctrl[C_CAP]),
         .evt   (cnt_evt && ctrl[C_CNT]),
         .latch (cap_latch),
         .ovf   (cap_ovf)
      );
   end else begin : g_no_cap
      assign cap_latch = '0;
      assign cap_ovf   = 1'b0;
   end

   // configuration registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl     <= '0;
         ceil_q   <= '1;
         unit_prd <= '0;
         wd_to    <= '1;
         imask    <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            A_CTRL:  ctrl     <= wr_data[NCTRL-1:0];
            A_PMAX:  ceil_q   <= wr_data[POS_W-1:0];
            A_UPRD:  unit_prd <= wr_data[UT_W-1:0];
            A_WDTO:  wd_to    <= wr_data[WD_W-1:0];
            A_IMSK:  imask    <= wr_data[NFLAG-1:0];
            default: ;
         endcase
      end
   end

   // position snapshot on unit period
   always_ff @(posedge clk) begin
      if (!rst_n)        pos_latch <= '0;
      else if (unit_hit) pos_latch <= pos_o;
   end

   // sticky flags, set wins over clear
   always_comb begin
      flag_set          = '0;
      flag_set[F_UNIT]  = unit_hit;
      flag_set[F_STALL] = stall_hit;
      flag_set[F_PERR]  = err_evt;
      flag_set[F_COVF]  = cap_ovf;
      flag_clr = (wr_en && wr_addr == A_FLAG) ? wr_data[NFLAG-1:0] : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) flags <= '0;
      else        flags <= (flags & ~flag_clr) | flag_set;
   end

   assign flags_o = flags;
   assign irq     = |(flags & imask);

   // read mux
   always_comb begin
      rd_data = '0;
      case (rd_addr)
         A_CTRL:  rd_data[NCTRL-1:0] = ctrl;
         A_POS:   rd_data[POS_W-1:0] = pos_o;
         A_PMAX:  rd_data[POS_W-1:0] = ceil_q;
         A_UPRD:  rd_data[UT_W-1:0]  = unit_prd;
         A_PLAT:  rd_data[POS_W-1:0] = pos_latch;
         A_WDTO:  rd_data[WD_W-1:0]  = wd_to;
         A_CLAT:  rd_data[CAP_W-1:0] = cap_latch;
         A_FLAG:  rd_data[NFLAG-1:0] = flags;
         A_IMSK:  rd_data[NFLAG-1:0] = imask;
         default: ;
      endcase
   end
endmodule

// File: rtl/qdec_checker.sv
module qdec_checker
   import qdec_pkg::*;
#(
   parameter int unsigned POS_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [REG_AW-1:0] wr_addr,
   input logic              cnt_evt,
   input logic              up_evt,
   input logic              err_evt,
   input logic              unit_hit,
   input logic              stall_hit,
   input logic              cap_ovf,
   input logic              count_en,
   input logic [POS_W-1:0]  pos_o,
   input logic              dir_o,
   input logic [POS_W-1:0]  pos_latch,
   input logic [NFLAG-1:0]  flags_o,
   input logic              irq
);
   logic pos_wr;
   assign pos_wr = wr_en && (wr_addr == A_POS);

   p_dir_up_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (count_en && cnt_evt && up_evt) |=> dir_o);
   p_dir_dn_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (count_en && cnt_evt && !up_evt) |=> !dir_o);
   p_err_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (err_evt && !pos_wr) |=> $stable(pos_o));
   p_err_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
      err_evt |=> flags_o[F_PERR]);
   p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!(count_en && cnt_evt) && !pos_wr) |=> $stable(pos_o));
   p_unit_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
      unit_hit |=> (pos_latch == $past(pos_o)));
   p_unit_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      unit_hit |=> flags_o[F_UNIT]);
   p_stall_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      stall_hit |=> flags_o[F_STALL]);
   p_cap_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cap_ovf |=> flags_o[F_COVF]);
   p_irq_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_o == '0) |-> !irq);
endmodule

bind qdec_top qdec_checker #(.POS_W(POS_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .cnt_evt   (cnt_evt),
   .up_evt    (up_evt),
   .err_evt   (err_evt),
   .unit_hit  (unit_hit),
   .stall_hit (stall_hit),
   .cap_ovf   (cap_ovf),
   .count_en  (ctrl[qdec_pkg::C_CNT]),
   .pos_o     (pos_o),
   .dir_o     (dir_o),
   .pos_latch (pos_latch),
   .flags_o   (flags_o),
   .irq       (irq)
);

// File: tb/qdec_top_tb_top.sv
module qdec_top_tb_top;
   import qdec_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int T_WD       = 15;
   localparam int P_UNIT     = 20;

   logic        clk = 1'b0, rst_n = 1'b0, qa = 1'b0, qb = 1'b0, wr_en = 1'b0;
   logic [3:0]  wr_addr = '0, rd_addr = '0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data, pos_o;
   logic        dir_o, irq;
   logic [3:0]  flags_o;

   qdec_top dut_i (
      .clk(clk), .rst_n(rst_n), .qa(qa), .qb(qb),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .pos_o(pos_o), .dir_o(dir_o), .flags_o(flags_o), .irq(irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk = 0, n_fail = 0;
   logic [31:0] m_pos = '0, m_max = '1;
   logic m_en = 1'b0, m_a = 1'b0, m_b = 1'b0, m_dir = 1'b0;

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] next_pos(input logic [31:0] p, input logic up,
                                            input logic [31:0] mx);
      if (up) return (p >= mx) ? 32'd0 : p + 32'd1;
      return (p == 32'd0) ? mx : p - 32'd1;
   endfunction

   task automatic wr(input logic [3:0] addr, input logic [31:0] data);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = addr; wr_data = data;
      @(negedge clk);
      wr_en = 1'b0;
      if (addr == A_POS)  m_pos = data;
      if (addr == A_PMAX) m_max = data;
      if (addr == A_CTRL) m_en  = data[C_CNT];
   endtask

   task automatic rd(input logic [3:0] addr, output logic [31:0] v);
      rd_addr = addr;
      #1 v = rd_data;
   endtask

   // drive new phase levels now (caller is at a falling edge)
   task automatic set_ab(input logic a, input logic b);
      logic ca, cb;
      ca = a ^ m_a; cb = b ^ m_b;
      if ((ca ^ cb) && m_en) begin
         m_dir = a ^ m_b;
         m_pos = next_pos(m_pos, m_dir, m_max);
      end
      qa = a; qb = b; m_a = a; m_b = b;
   endtask

   task automatic drive_step(input logic fwd);
      if (fwd) set_ab(~m_b, m_a);
      else     set_ab(m_b, ~m_a);
   endtask

   task automatic step_chk(input logic fwd, input string req);
      @(negedge clk);
      drive_step(fwd);
      @(negedge clk);
      check(req, "position", pos_o, m_pos);
      check(req, "direction", {31'd0, dir_o}, {31'd0, m_dir});
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      summary();
   end

   initial begin
      logic [31:0] v;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      check("R9", "pos after reset", pos_o, 0);
      check("R9", "dir after reset", {31'd0, dir_o}, 0);
      check("R9", "flags after reset", {28'd0, flags_o}, 0);
      check("R9", "irq after reset", {31'd0, irq}, 0);

      // R10 counting disabled
      step_chk(1'b1, "R10");
      step_chk(1'b1, "R10");
      check("R10", "pos held while disabled", pos_o, 0);

      // R1 forward then reverse
      wr(A_CTRL, 32'h1);
      for (int i = 0; i < 8; i++) step_chk(1'b1, "R1");
      check("R1", "eight up steps", pos_o, 8);
      for (int i = 0; i < 3; i++) step_chk(1'b0, "R1");
      check("R1", "three down steps", pos_o, 5);

      // R4 position load
      wr(A_POS, 32'd100);
      check("R4", "loaded position", pos_o, 100);

      // R2 wrap both ways
      wr(A_PMAX, 32'd5);
      wr(A_POS, 32'd4);
      step_chk(1'b1, "R2");
      step_chk(1'b1, "R2");
      check("R2", "wrap to zero", pos_o, 0);
      step_chk(1'b0, "R2");
      check("R2", "wrap to ceiling", pos_o, 5);
      step_chk(1'b0, "R2");

      // R3 simultaneous change
      @(negedge clk);
      set_ab(~m_a, ~m_b);
      @(negedge clk);
      check("R3", "pos unchanged on double change", pos_o, m_pos);
      check("R3", "phase error flag", {31'd0, flags_o[F_PERR]}, 1);
      // R8 write-one clear and masking
      check("R8", "irq masked", {31'd0, irq}, 0);
      wr(A_IMSK, 32'h4);
      check("R8", "irq with mask", {31'd0, irq}, 1);
      wr(A_FLAG, 32'h4);
      check("R8", "flag cleared", {28'd0, flags_o}, 0);
      check("R8", "irq after clear", {31'd0, irq}, 0);
      wr(A_IMSK, 32'h0);

      // R1/R2/R3 random walk
      wr(A_PMAX, 32'd9);
      wr(A_POS, 32'd0);
      for (int i = 0; i < 400; i++) begin
         int r;
         r = int'($urandom % 5);
         if (r <= 1)      step_chk(1'b1, "R1");
         else if (r == 2) step_chk(1'b0, "R2");
         else if (r == 3) begin
            @(negedge clk); @(negedge clk);
            check("R10", "idle hold", pos_o, m_pos);
         end else begin
            @(negedge clk);
            set_ab(~m_a, ~m_b);
            @(negedge clk);
            check("R3", "random double change", pos_o, m_pos);
            check("R3", "random error flag", {31'd0, flags_o[F_PERR]}, 1);
         end
      end
      wr(A_FLAG, 32'hF);

      // R5 unit timer
      wr(A_POS, 32'd7);
      wr(A_UPRD, P_UNIT);
      wr(A_CTRL, 32'h3);
      repeat (P_UNIT) @(negedge clk);
      check("R5", "unit flag one edge early", {31'd0, flags_o[F_UNIT]}, 0);
      @(negedge clk);
      check("R5", "unit flag on time", {31'd0, flags_o[F_UNIT]}, 1);
      rd(A_PLAT, v);
      check("R5", "latched position", v, 7);
      wr(A_CTRL, 32'h1);
      wr(A_FLAG, 32'hF);

      // R7 watchdog
      wr(A_WDTO, T_WD);
      wr(A_CTRL, 32'h5);
      repeat (T_WD) @(negedge clk);
      check("R7", "no stall before timeout", {31'd0, flags_o[F_STALL]}, 0);
      drive_step(1'b1);
      repeat (T_WD + 1) @(negedge clk);
      check("R7", "edge restarted watchdog", {31'd0, flags_o[F_STALL]}, 0);
      @(negedge clk);
      check("R7", "stall flag on time", {31'd0, flags_o[F_STALL]}, 1);
      wr(A_CTRL, 32'h1);
      wr(A_FLAG, 32'hF);

      // R6 capture
      wr(A_CTRL, 32'h9);
      @(negedge clk);
      drive_step(1'b1);
      repeat (12) @(negedge clk);
      drive_step(1'b1);
      @(negedge clk);
      rd(A_CLAT, v);
      check("R6", "interval of 12", v, 12);
      repeat (36) @(negedge clk);
      drive_step(1'b0);
      @(negedge clk);
      rd(A_CLAT, v);
      check("R6", "interval of 37", v, 37);
      check("R6", "position after capture steps", pos_o, m_pos);
      repeat (65000) @(negedge clk);
      check("R6", "no overflow yet", {31'd0, flags_o[F_COVF]}, 0);
      repeat (1000) @(negedge clk);
      check("R6", "overflow flag", {31'd0, flags_o[F_COVF]}, 1);

      summary();
   end
endmodule